// File: doc/BRIEF.md
# Many-Time-Programmable Memory Device Emulator

This block stands in for a byte-wide, electrically erasable memory device so that the control logic of a device programmer can be tested against it on chip. Every clock it decodes five control levels into one operating mode. The levels are chip select, output gate, an active-low program/erase strobe, a flag meaning "high voltage present on the identification address pin" and a flag meaning "programming supply present". The mode then decides whether the block drives its output byte and what that byte is. It also decides whether a strobe edge writes to the internal byte array or clears all of it.

Programming follows the physics of the real cells. A write can only pull bits from 1 to 0, so the stored value is the old byte ANDed with the new one. Only a whole-array erase brings bits back to 1. An identification mode returns a fixed manufacturer byte and a parameterised device byte, chosen by the lowest address bit. A sticky flag reports any program or erase strobe whose low time, counted in clock cycles, falls outside the allowed window for that operation.

The interface is level-based, like the pins of the device it models. There is no valid/ready handshake and no back-pressure: `dout_en` is the only qualifier, and `dout` is meaningful only while it is high. The strobe inputs act on their falling edge, sampled by `clk`.

Top module: `mtp_flash_emu`

## Requirements
- R1: While `ce_n` is high the block is in standby: `dout_en` is 0 and `dout` is 00h, whatever the other inputs are.
- R2: With `ce_n`=0, `oe_n`=0, `vpp_on`=0 and `hv_flag`=0, `dout_en` is 1 and `dout` equals the stored byte at `addr`. The value is combinational on `addr`, and a write made at a clock edge is visible right after that edge.
- R3: With `ce_n`=0 and either `vpp_on`=1 (any `oe_n`) or `vpp_on`=0 with `oe_n`=1, the output is not driven: `dout_en`=0 and `dout`=00h.
- R4: With `ce_n`=0, `vpp_on`=1 and `hv_flag`=0, the clock edge that first samples `strobe_n` low after it was high writes to the byte at `addr`, using `din` from that edge.
- R5: A write stores (old byte AND `din`), so no bit ever goes from 0 to 1 through programming.
- R6: With `ce_n`=0, `vpp_on`=1 and `hv_flag`=1, the first clock edge sampling `strobe_n` low sets every byte of the array to FFh.
- R7: With `ce_n`=0, `vpp_on`=0, `oe_n`=0 and `hv_flag`=1, `dout_en` is 1. `dout` is BFh when `addr` is 0, `DEV_CODE` when `addr` is 1, and 00h for any address with an upper bit set.
- R8: While `ce_n` is high, a strobe falling edge changes no byte, even with `vpp_on`=1 and `hv_flag`=1.
- R9: After reset every byte reads FFh and `pulse_err` is 0.
- R10: Let L be the number of clock edges that sample `strobe_n` low during a timed program or erase pulse. When the strobe returns high, `pulse_err` is set if L < MIN or L > MAX for that operation. Pulses of exactly MIN or MAX cycles are legal. Once set, `pulse_err` stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip select |
| oe_n | input | 1 | Active-low output gate |
| strobe_n | input | 1 | Active-low program/erase strobe |
| hv_flag | input | 1 | High voltage present on the identification address pin |
| vpp_on | input | 1 | Programming supply present |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Byte to program |
| dout | output | 8 | Read or identification byte, 00h when not driven |
| dout_en | output | 1 | Output drive enable |
| pulse_err | output | 1 | Sticky strobe-width violation flag |

## Verification
Array state is only visible through read mode, so a corrupted or wrongly merged byte shows up on `dout` in the first read cycle after the faulty edge. The bench reads back every address it touched right after the strobe, including one that was never written. A mode decoding error shows the same cycle as a wrong `dout_en`. A pulse counter that is off by one shows only when the strobe rises, because the check is made there. For that reason pulses are driven at exactly MIN and MAX as well as one step outside the window.

// File: rtl/mtp_emu_pkg.sv
package mtp_emu_pkg;

  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] MFR_CODE = 8'hBF;
  localparam logic [BYTE_W-1:0] ERASED   = 8'hFF;
  localparam logic [BYTE_W-1:0] FLOAT    = 8'h00;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_INHIBIT,
    MD_READ,
    MD_DISABLE,
    MD_IDENT,
    MD_PROGRAM,
    MD_ERASE
  } mode_t;

  typedef enum logic [1:0] {
    PK_IDLE,
    PK_PROG,
    PK_ERASE
  } pulse_kind_t;

endpackage

// File: rtl/mtp_mode_decode.sv
module mtp_mode_decode
  import mtp_emu_pkg::*;
(
  input  logic  ce_n,
  input  logic  oe_n,
  input  logic  hv_flag,
  input  logic  vpp_on,
  output mode_t mode
);

  always_comb begin
    if (ce_n) begin
      mode = vpp_on ? MD_INHIBIT : MD_STANDBY;
    end else if (vpp_on) begin
      mode = hv_flag ? MD_ERASE : MD_PROGRAM;
    end else if (oe_n) begin
      mode = MD_DISABLE;
    end else begin
      mode = hv_flag ? MD_IDENT : MD_READ;
    end
  end

endmodule

// File: rtl/mtp_cell_array.sv
module mtp_cell_array
  import mtp_emu_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic              erase_all,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [BYTE_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n || erase_all) begin
      for (int i = 0; i < DEPTH; i++) begin
        cells[i] <= ERASED;
      end
    end else if (prog_we) begin
      cells[addr] <= cells[addr] & wdata;
    end
  end

  assign rdata = cells[addr];

endmodule

// File: rtl/mtp_strobe_timer.sv
module mtp_strobe_timer
  import mtp_emu_pkg::*;
#(
  parameter int PROG_MIN  = 4,
  parameter int PROG_MAX  = 6,
  parameter int ERASE_MIN = 20,
  parameter int ERASE_MAX = 100
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  strobe_n,
  input  mode_t mode,
  output logic  fall,
  output logic  pulse_err
);

  localparam int LIMIT = ((ERASE_MAX > PROG_MAX) ? ERASE_MAX : PROG_MAX) + 1;
  localparam int CNT_W = $clog2(LIMIT + 1);
  localparam logic [CNT_W-1:0] SAT   = CNT_W'(LIMIT);
  localparam logic [CNT_W-1:0] P_MIN = CNT_W'(PROG_MIN);
  localparam logic [CNT_W-1:0] P_MAX = CNT_W'(PROG_MAX);
  localparam logic [CNT_W-1:0] E_MIN = CNT_W'(ERASE_MIN);
  localparam logic [CNT_W-1:0] E_MAX = CNT_W'(ERASE_MAX);

  logic             strobe_q;
  logic             rise;
  logic [CNT_W-1:0] width;
  pulse_kind_t      kind;
  logic             out_of_window;

  assign fall = strobe_q && !strobe_n;
  assign rise = !strobe_q && strobe_n;

  always_comb begin
    unique case (kind)
      PK_PROG:  out_of_window = (width < P_MIN) || (width > P_MAX);
      PK_ERASE: out_of_window = (width < E_MIN) || (width > E_MAX);
      default:  out_of_window = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q  <= 1'b1;
      width     <= '0;
      kind      <= PK_IDLE;
      pulse_err <= 1'b0;
    end else begin
      strobe_q <= strobe_n;
      if (fall) begin
        width <= CNT_W'(1);
        if (mode == MD_PROGRAM)    kind <= PK_PROG;
        else if (mode == MD_ERASE) kind <= PK_ERASE;
        else                       kind <= PK_IDLE;
      end else if (rise) begin
        if (out_of_window) pulse_err <= 1'b1;
        kind  <= PK_IDLE;
        width <= '0;
      end else if (!strobe_n && kind != PK_IDLE && width != SAT) begin
        width <= width + 1'b1;
      end
    end
  end

endmodule

// File: rtl/mtp_flash_emu.sv
module mtp_flash_emu
  import mtp_emu_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [7:0]  DEV_CODE  = 8'hA4,
  parameter int          PROG_MIN  = 4,
  parameter int          PROG_MAX  = 6,
  parameter int          ERASE_MIN = 20,
  parameter int          ERASE_MAX = 100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              strobe_n,
  input  logic              hv_flag,
  input  logic              vpp_on,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  output logic [7:0]        dout,
  output logic              dout_en,
  output logic              pulse_err
);

  mode_t       mode;
  logic        fall;
  logic        prog_fire;
  logic        erase_fire;
  logic [7:0]  cell_rd;
  logic        id_upper_zero;

  mtp_mode_decode u_decode (
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .hv_flag (hv_flag),
    .vpp_on  (vpp_on),
    .mode    (mode)
  );

  mtp_strobe_timer #(
    .PROG_MIN  (PROG_MIN),
    .PROG_MAX  (PROG_MAX),
    .ERASE_MIN (ERASE_MIN),
    .ERASE_MAX (ERASE_MAX)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_n  (strobe_n),
    .mode      (mode),
    .fall      (fall),
    .pulse_err (pulse_err)
  );

  assign prog_fire  = fall && (mode == MD_PROGRAM);
  assign erase_fire = fall && (mode == MD_ERASE);

  mtp_cell_array #(
    .ADDR_W (ADDR_W)
  ) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .prog_we   (prog_fire),
    .erase_all (erase_fire),
    .addr      (addr),
    .wdata     (din),
    .rdata     (cell_rd)
  );

  assign id_upper_zero = (addr >> 1) == '0;

  always_comb begin
    dout_en = 1'b0;
    dout    = FLOAT;
    unique case (mode)
      MD_READ: begin
        dout_en = 1'b1;
        dout    = cell_rd;
      end
      MD_IDENT: begin
        dout_en = 1'b1;
        if (id_upper_zero) dout = addr[0] ? DEV_CODE : MFR_CODE;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/mtp_flash_emu_chk.sv
module mtp_flash_emu_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_n,
  input logic              oe_n,
  input logic              hv_flag,
  input logic              vpp_on,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        din,
  input logic [7:0]        dout,
  input logic              dout_en,
  input logic              pulse_err,
  input logic              prog_fire,
  input logic              erase_fire
);

  logic rd_mode;
  assign rd_mode = !ce_n && !oe_n && !vpp_on && !hv_flag;

  // R1
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> (!dout_en && dout == 8'h00));

  // R3
  no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && (vpp_on || oe_n)) |-> !dout_en);

  // R7
  id_mfr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce_n && !oe_n && !vpp_on && hv_flag && addr == '0) |-> (dout_en && dout == 8'hBF));

  // R8
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !(prog_fire || erase_fire));

  // R5
  clear_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(prog_fire) && rd_mode && addr == $past(addr))
      |-> ((dout & ~$past(din)) == 8'h00));

  // R6
  erase_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(erase_fire) && rd_mode) |-> (dout == 8'hFF));

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_err |=> pulse_err);

endmodule

bind mtp_flash_emu mtp_flash_emu_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_n       (ce_n),
  .oe_n       (oe_n),
  .hv_flag    (hv_flag),
  .vpp_on     (vpp_on),
  .addr       (addr),
  .din        (din),
  .dout       (dout),
  .dout_en    (dout_en),
  .pulse_err  (pulse_err),
  .prog_fire  (prog_fire),
  .erase_fire (erase_fire)
);

// File: tb/test_mtp_flash_emu.sv
module test_mtp_flash_emu;

  localparam int AW = 4;
  localparam logic [7:0] DEV = 8'hA5;

  // mode bit order: ce_n, oe_n, strobe_n, hv_flag, vpp_on
  localparam logic [4:0] M_READ = 5'b00100;
  localparam logic [4:0] M_PSET = 5'b01101;
  localparam logic [4:0] M_PSTR = 5'b01001;
  localparam logic [4:0] M_PSOE = 5'b00101;
  localparam logic [4:0] M_IHST = 5'b11001;
  localparam logic [4:0] M_IHRL = 5'b11101;
  localparam logic [4:0] M_IEST = 5'b11011;
  localparam logic [4:0] M_IERL = 5'b11111;
  localparam logic [4:0] M_ID   = 5'b00110;
  localparam logic [4:0] M_DIS  = 5'b01100;
  localparam logic [4:0] M_STBY = 5'b10100;
  localparam logic [4:0] M_ESET = 5'b01111;
  localparam logic [4:0] M_ESTR = 5'b01011;

  // {mode, addr, din, exp_en, exp_dout}
  localparam int NV = 27;
  localparam logic [25:0] VEC [NV] = '{
    {M_READ, 4'h3, 8'h00, 1'b1, 8'hFF},  // R2 erased byte
    {M_PSET, 4'h3, 8'h5A, 1'b0, 8'h00},  // R3
    {M_PSTR, 4'h3, 8'h5A, 1'b0, 8'h00},  // R4 write fires
    {M_PSET, 4'h3, 8'h5A, 1'b0, 8'h00},
    {M_READ, 4'h3, 8'h00, 1'b1, 8'h5A},  // R4 readback
    {M_PSTR, 4'h3, 8'h0F, 1'b0, 8'h00},  // R5 second write
    {M_PSET, 4'h3, 8'h0F, 1'b0, 8'h00},
    {M_READ, 4'h3, 8'h00, 1'b1, 8'h0A},  // R5 AND merge
    {M_IHST, 4'h3, 8'h00, 1'b0, 8'h00},  // R8 strobe while deselected
    {M_IHRL, 4'h3, 8'h00, 1'b0, 8'h00},
    {M_READ, 4'h3, 8'h00, 1'b1, 8'h0A},  // R8 byte unchanged
    {M_ID,   4'h0, 8'h00, 1'b1, 8'hBF},  // R7
    {M_ID,   4'h1, 8'h00, 1'b1, DEV},    // R7
    {M_ID,   4'h2, 8'h00, 1'b1, 8'h00},  // R7 upper bit set
    {M_DIS,  4'h3, 8'h00, 1'b0, 8'h00},  // R3
    {M_STBY, 4'h3, 8'h00, 1'b0, 8'h00},  // R1
    {M_PSTR, 4'h5, 8'h33, 1'b0, 8'h00},  // R4
    {M_PSET, 4'h5, 8'h33, 1'b0, 8'h00},
    {M_READ, 4'h5, 8'h00, 1'b1, 8'h33},  // R4
    {M_READ, 4'h0, 8'h00, 1'b1, 8'hFF},  // R2 untouched address
    {M_ESET, 4'h0, 8'h00, 1'b0, 8'h00},
    {M_ESTR, 4'h0, 8'h00, 1'b0, 8'h00},  // R6 erase fires
    {M_ESTR, 4'h0, 8'h00, 1'b0, 8'h00},
    {M_ESET, 4'h0, 8'h00, 1'b0, 8'h00},
    {M_READ, 4'h3, 8'h00, 1'b1, 8'hFF},  // R6
    {M_READ, 4'h5, 8'h00, 1'b1, 8'hFF},  // R6
    {M_PSOE, 4'h3, 8'h00, 1'b0, 8'h00}   // R3 supply on, gate low
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ce_n = 1'b1, oe_n = 1'b1, strobe_n = 1'b1, hv_flag = 1'b0, vpp_on = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    din = '0;
  logic [7:0]    dout;
  logic          dout_en, pulse_err;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #5 clk = ~clk;

  mtp_flash_emu #(
    .ADDR_W (AW), .DEV_CODE (DEV),
    .PROG_MIN (1), .PROG_MAX (3), .ERASE_MIN (2), .ERASE_MAX (5)
  ) i_mtp_flash_emu (
    .clk (clk), .rst_n (rst_n), .ce_n (ce_n), .oe_n (oe_n), .strobe_n (strobe_n),
    .hv_flag (hv_flag), .vpp_on (vpp_on), .addr (addr), .din (din),
    .dout (dout), .dout_en (dout_en), .pulse_err (pulse_err)
  );

  task automatic step(input logic [4:0] m, input logic [AW-1:0] a, input logic [7:0] d);
    {ce_n, oe_n, strobe_n, hv_flag, vpp_on} = m;
    addr = a;
    din  = d;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [4:0] m);
    if (m[4])      return m[0] ? "R8" : "R1";
    if (m[0])      return "R3";
    if (m[3])      return "R3";
    if (m[1])      return "R7";
    return "R2";
  endfunction

  task automatic do_reset();
    {ce_n, oe_n, strobe_n, hv_flag, vpp_on} = M_STBY;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 standby after reset, R9 flag clear
    check("R1", {dout_en, dout}, 9'h000);
    check("R9", {8'h00, pulse_err}, 9'h000);
    step(M_READ, 4'h9, 8'h00);
    check("R9", {dout_en, dout}, {1'b1, 8'hFF});

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][25:21], VEC[i][20:17], VEC[i][16:9]);
      check(tag_of(VEC[i][25:21]), {dout_en, dout}, VEC[i][8:0]);
    end
    // R10 legal pulses (program 1 = min, erase 2 = min) leave flag clear
    check("R10", {8'h00, pulse_err}, 9'h000);

    // R10 program pulse of 4 cycles exceeds max 3
    step(M_PSET, 4'h7, 8'h00);
    repeat (4) step(M_PSTR, 4'h7, 8'h00);
    step(M_PSET, 4'h7, 8'h00);
    check("R10", {8'h00, pulse_err}, 9'h001);
    step(M_READ, 4'h7, 8'h00);
    check("R4", {dout_en, dout}, {1'b1, 8'h00});
    step(M_STBY, 4'h0, 8'h00);
    check("R10", {8'h00, pulse_err}, 9'h001);

    // R9 reset restores array and flag
    do_reset();
    check("R9", {8'h00, pulse_err}, 9'h000);
    step(M_READ, 4'h7, 8'h00);
    check("R9", {dout_en, dout}, {1'b1, 8'hFF});

    // R10 erase pulse of 1 cycle is below min 2
    step(M_ESET, 4'h0, 8'h00);
    step(M_ESTR, 4'h0, 8'h00);
    step(M_ESET, 4'h0, 8'h00);
    check("R10", {8'h00, pulse_err}, 9'h001);

    // R10 boundaries: program 3 cycles (max), erase 5 cycles (max)
    do_reset();
    step(M_PSET, 4'h2, 8'h00);
    repeat (3) step(M_PSTR, 4'h2, 8'h00);
    step(M_PSET, 4'h2, 8'h00);
    check("R10", {8'h00, pulse_err}, 9'h000);
    step(M_READ, 4'h2, 8'h00);
    check("R4", {dout_en, dout}, {1'b1, 8'h00});

    // R8 erase strobe while deselected leaves the byte programmed
    step(M_IEST, 4'h2, 8'h00);
    step(M_IERL, 4'h2, 8'h00);
    step(M_READ, 4'h2, 8'h00);
    check("R8", {dout_en, dout}, {1'b1, 8'h00});

    step(M_ESET, 4'h0, 8'h00);
    repeat (5) step(M_ESTR, 4'h0, 8'h00);
    step(M_ESET, 4'h0, 8'h00);
    check("R10", {8'h00, pulse_err}, 9'h000);
    step(M_READ, 4'h2, 8'h00);
    check("R6", {dout_en, dout}, {1'b1, 8'hFF});

    // R5 programming a 1 over a 0 keeps the 0
    step(M_PSTR, 4'hF, 8'hF0);
    step(M_PSET, 4'hF, 8'hF0);
    step(M_PSTR, 4'hF, 8'hFF);
    step(M_PSET, 4'hF, 8'hFF);
    step(M_READ, 4'hF, 8'h00);
    check("R5", {dout_en, dout}, {1'b1, 8'hF0});

    finish_run();
  end

endmodule